// File: doc/BRIEF.md
# ECP Forward Command/Data Transmit FIFO

This block is the host-side transmit path of an ECP-mode parallel port in the forward (host to peripheral) direction. Software writes bytes through a small register bus. A write to the address/RLE register queues the byte as a command. A write to the data register queues it as data. Each queue entry holds 8 data bits and a 1-bit command tag.

A transmit engine drains the queue without any further help from software. For every entry it presents the byte on the 8-bit peripheral bus and sets the host-acknowledge line to show the entry type. It then strobes the byte with the host clock and completes the four-phase handshake with the peripheral's acknowledge.

A command byte carries one of two meanings, chosen by its most significant bit:
- With bit 7 set, bits 6..0 are a channel address.
- With bit 7 clear, bits 6..0 are a repeat count N. The next data byte is meant to appear N+1 times.

The host sends both the count and the data byte unchanged, and the peripheral does the expansion.

Top module: `ecp_fwd_tx`

## Requirements
- R1: After reset, `pd` is 00h, `host_clk` and `host_ack` are high, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: A write with `wr_sel`=1 (address/RLE register) queues the byte as a command. That byte is later sent with `host_ack` low while `host_clk` is low.
- R3: A write with `wr_sel`=0 (data register) queues the byte as data. That byte is later sent with `host_ack` high while `host_clk` is low.
- R4: Writes are ignored unless `ecp_sel`=1 and `port_mode`=3'b011. An ignored write queues nothing and sends nothing.
- R5: The queue holds 16 entries and sends them in write order. `fifo_full` rises when all 16 entries are occupied. A write while full is dropped.
- R6: `host_clk` falls only after the byte has been presented. It stays low until `periph_ack` is high. After `host_clk` rises again, no new byte is presented until `periph_ack` is low.
- R7: `pd` and `host_ack` do not change while `host_clk` is low.
- R8: Command bytes are sent unchanged, for both an address (bit 7 = 1) and a repeat count (bit 7 = 0). A repeat count followed by a data byte produces exactly two transfers; the host does not expand the repeat.
- R9: Queued entries are sent automatically, with no action beyond the register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 1: address/RLE register, 0: data register |
| wr_data | input | 8 | Write data |
| ecp_sel | input | 1 | Port is configured for ECP operation |
| port_mode | input | 3 | Extended-control mode field; 3'b011 enables the queue |
| periph_ack | input | 1 | Peripheral acknowledge |
| pd | output | 8 | Peripheral data bus |
| host_clk | output | 1 | Host strobe, active low |
| host_ack | output | 1 | Low for a command byte, high for a data byte |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_empty | output | 1 | Queue holds no entries |

## Verification
The handshake assertions assume the peripheral behaves. It raises `periph_ack` only while `host_clk` is low, and it drops `periph_ack` only after `host_clk` has risen. The queue-empty assertion assumes that the mode inputs stay constant across the sampled cycle.

The bench drives `periph_ack` from a peripheral model that follows this order and changes only on falling clock edges. The model can be paused to hold the handshake, which stalls the engine and fills the queue. Mode changes are made only when the queue is empty and the engine is idle.

// File: rtl/ecp_fwd_tx.sv
module ecp_fwd_tx #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  parameter logic [2:0] QMODE = 3'b011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ecp_sel,
  input  logic [2:0]    port_mode,
  input  logic          periph_ack,
  output logic [DW-1:0] pd,
  output logic          host_clk,
  output logic          host_ack,
  output logic          fifo_full,
  output logic          fifo_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_RELEASE} st_t;

  st_t            st;
  logic [EW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [AW:0]    cnt;
  logic [DW-1:0]  pd_q;
  logic           hclk_q, hack_q;

  wire mode_ok = ecp_sel && (port_mode == QMODE);
  wire push    = wr_en && mode_ok && !fifo_full;
  wire pop     = (st == S_IDLE) && !fifo_empty && mode_ok;

  assign fifo_full  = (cnt == (AW+1)'(DEPTH));
  assign fifo_empty = (cnt == '0);
  assign pd         = pd_q;
  assign host_clk   = hclk_q;
  assign host_ack   = hack_q;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_sel, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pd_q   <= '0;
      hclk_q <= 1'b1;
      hack_q <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (pop) begin
          pd_q   <= mem[rp][DW-1:0];
          hack_q <= !mem[rp][DW];
          st     <= S_SETUP;
        end
        S_SETUP: begin
          hclk_q <= 1'b0;
          st     <= S_STROBE;
        end
        S_STROBE: if (periph_ack) begin
          hclk_q <= 1'b1;
          st     <= S_RELEASE;
        end
        default: if (!periph_ack) st <= S_IDLE;
      endcase
    end
  end

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop) |=> fifo_full);

  p_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !(ecp_sel && port_mode == QMODE)) |=> fifo_empty);

  p_wait_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_clk && !periph_ack) |=> !host_clk);

  p_wait_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clk && periph_ack) |=> (host_clk && $stable(pd)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_clk |=> ($stable(pd) && $stable(host_ack)));

endmodule

// File: tb/test_ecp_fwd_tx.sv
module test_ecp_fwd_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {wr_sel, byte}: wr_sel=1 command, 0 data
  localparam logic [8:0] VEC [NVEC] = '{
    9'h185, 9'h041, 9'h105, 9'h0AA, 9'h1FF, 9'h100, 9'h000, 9'h07E
  };

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wr_sel = 0, ecp_sel = 1, periph_ack = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] port_mode = 3'b011;
  logic [7:0] pd;
  logic       host_clk, host_ack, fifo_full, fifo_empty;

  int nchk = 0, nerr = 0, ncap = 0;
  bit periph_go = 1;
  logic [7:0] cap_b [64];
  logic       cap_t [64];

  ecp_fwd_tx i_ecp_fwd_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ecp_sel(ecp_sel), .port_mode(port_mode), .periph_ack(periph_ack),
    .pd(pd), .host_clk(host_clk), .host_ack(host_ack),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (rst_n && !host_clk && !periph_ack && periph_go) begin
      if (ncap < 64) begin
        cap_b[ncap] = pd;
        cap_t[ncap] = host_ack;
      end
      ncap++;
      periph_ack = 1;
    end else if (host_clk && periph_ack) begin
      periph_ack = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_cap(input int n);
    for (int k = 0; k < 2000 && ncap < n; k++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pd == 8'h00 && host_clk && host_ack && fifo_empty && !fifo_full, "R1",
        {pd, host_clk, host_ack, fifo_empty, fifo_full}, 12'h00E);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Table walk: R2, R3, R8, R9
    for (int i = 0; i < NVEC; i++) wr(VEC[i][8], VEC[i][7:0]);
    wait_cap(NVEC);
    repeat (40) @(negedge clk);
    chk(ncap == NVEC, "R8 no expansion / R9 auto send", ncap, NVEC);
    for (int i = 0; i < NVEC; i++) begin
      chk(cap_b[i] == VEC[i][7:0], "R8 byte unchanged", cap_b[i], VEC[i][7:0]);
      chk(cap_t[i] == !VEC[i][8], VEC[i][8] ? "R2 command host_ack" : "R3 data host_ack",
          cap_t[i], !VEC[i][8]);
    end

    // Fill: R5, R6, R7
    periph_go = 0;
    for (int i = 0; i < 20; i++) wr(1'b0, 8'h10 + 8'(i));
    repeat (30) @(negedge clk);
    chk(fifo_full == 1, "R5 full flag", fifo_full, 1);
    chk(host_clk == 0 && ncap == NVEC, "R6 strobe held without ack", host_clk, 0);
    chk(pd == 8'h10, "R7 byte presented", pd, 8'h10);
    repeat (10) @(negedge clk);
    chk(pd == 8'h10 && host_ack == 1 && host_clk == 0, "R7 stable while strobed", pd, 8'h10);
    periph_go = 1;
    wait_cap(NVEC + 17);
    repeat (40) @(negedge clk);
    chk(ncap == NVEC + 17, "R5 writes while full dropped", ncap, NVEC + 17);
    for (int k = 0; k < 17; k++)
      chk(cap_b[NVEC+k] == 8'h10 + 8'(k), "R5 order", cap_b[NVEC+k], 8'h10 + 8'(k));
    chk(fifo_empty == 1, "R5 drained", fifo_empty, 1);

    // Ignored writes: R4
    port_mode = 3'b001;
    wr(1'b1, 8'h99); wr(1'b0, 8'h55);
    repeat (20) @(negedge clk);
    chk(fifo_empty && host_clk && ncap == NVEC + 17, "R4 wrong mode", ncap, NVEC + 17);
    port_mode = 3'b011; ecp_sel = 0;
    wr(1'b1, 8'h99); wr(1'b0, 8'h55);
    repeat (20) @(negedge clk);
    chk(fifo_empty && host_clk && ncap == NVEC + 17, "R4 not ECP", ncap, NVEC + 17);
    ecp_sel = 1;
    repeat (20) @(negedge clk);
    chk(ncap == NVEC + 17, "R4 nothing queued", ncap, NVEC + 17);

    // Command after re-enable: R2
    wr(1'b1, 8'hC3);
    wait_cap(NVEC + 18);
    repeat (5) @(negedge clk);
    chk(ncap == NVEC + 18 && cap_b[NVEC+17] == 8'hC3 && cap_t[NVEC+17] == 0,
        "R2 address command", cap_b[NVEC+17], 8'hC3);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule